// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Multiprocessor Wake

This block takes one non-return-to-zero serial line and turns the frames on it into characters in a receive FIFO. A frame has one low start bit, then 1 to 8 data bits sent least significant bit first, then an optional parity bit, then an optional address bit, then one or two high stop bits. The bit clock is set by a 16-bit divisor. The line passes through a two-flop synchronizer and is sampled sixteen times per bit. Each bit value is the majority of three samples taken around mid-bit.

Each stored character carries an address flag. In idle-line wake mode, the flag marks the first character after a long high gap. In address-bit wake mode, the flag is the value of the extra address bit. While the sleep input is high, only characters with the address flag set are kept. The surrounding controller reads characters through a show-ahead port. Four sticky error flags report faults: parity, framing, overrun and break. Their OR forms the error interrupt, and a single clear input resets all four.

Top module: `nrz_rx_wake`

## Requirements
- R1: A frame is one start bit, then `char_len_i`+1 data bits LSB first, and the character is stored right-aligned with its unused upper bits zero (code 0 gives 1 bit, code 7 gives 8 bits).
- R2: One bit lasts 16*(`baud_div_i`+1) clock cycles. A low pulse on an idle line much shorter than half a bit is treated as a false start and stores nothing.
- R3: With `par_en_i` high, a parity bit follows the data. Even parity (`par_odd_i`=0) expects the XOR of the data bits, and odd parity expects its inverse. A mismatch sets `err_parity_o`.
- R4: The frame ends with one stop bit, or two when `two_stop_i` is high. A low value in any stop bit sets `err_frame_o`.
- R5: The FIFO holds 16 characters. `rx_rdy_o` is high when it is not empty. `fifo_count_o` gives the fill level. The head entry appears on `rd_data_o`/`rd_addr_o`, and `rd_i` removes it on the next clock.
- R6: A character that completes while the FIFO is full is dropped, the FIFO is left unchanged, and `err_overrun_o` is set.
- R7: `brk_o` sets when the line has been low for a whole frame (all bits, stop bits included) and then for at least 10 more bit times. A low run only 5 bit times past the frame does not set it.
- R8: `rx_err_o` is the OR of the four error flags.
- R9: With `wake_mode_i`=1 (idle-line), a character is marked as an address when it follows 10 or more high bit times.
- R10: With `wake_mode_i`=2 (address-bit), an extra bit after data and parity gives the character's address flag. With `wake_mode_i`=0, the flag is always 0.
- R11: While `sleep_i` is high, characters without the address flag are neither stored nor able to set any error flag.
- R12: After reset the FIFO is empty and all error flags are low.
- R13: The error flags stay set until `clr_err_i` is high for one clock, which clears all four.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rxd_i | input | 1 | Serial line, idle high |
| baud_div_i | input | 16 | Oversample tick period minus one |
| char_len_i | input | 3 | Data bits per character minus one |
| par_en_i | input | 1 | Parity bit present |
| par_odd_i | input | 1 | 1 selects odd parity, 0 selects even |
| two_stop_i | input | 1 | Two stop bits |
| wake_mode_i | input | 2 | 0 none, 1 idle-line, 2 address-bit |
| sleep_i | input | 1 | Keep only address characters |
| rd_i | input | 1 | Remove the head character |
| clr_err_i | input | 1 | Clear all error flags |
| rd_data_o | output | 8 | Head character |
| rd_addr_o | output | 1 | Address flag of the head character |
| rx_rdy_o | output | 1 | FIFO not empty |
| fifo_count_o | output | 5 | FIFO fill level |
| err_parity_o | output | 1 | Sticky parity fault |
| err_overrun_o | output | 1 | Sticky overrun fault |
| err_frame_o | output | 1 | Sticky framing fault |
| brk_o | output | 1 | Sticky break detect |
| rx_err_o | output | 1 | Error interrupt, OR of the flags |

## Verification
A character and its parity, framing and overrun flags are committed at the middle of the last stop bit. That point lies two synchronizer cycles plus at most one tick after the line is sampled there, so it always falls well before the stop bit ends. The bench therefore marks each frame as in flight from its start bit through one trailing guard bit. It applies the expected result to its reference model only after that window closes, and it compares FIFO level, head entry and flags on every clock outside the window. A read or a clear is sampled on the next rising edge, so the bench updates its model at that same edge and the next comparison sees both sides change together. Break is checked after the line has returned high, which is well past the point where the low-run counter reaches 10 bit times.

// File: rtl/nrz_rx_wake.sv
module nrz_rx_wake #(
  parameter int DIV_W      = 16,
  parameter int DEPTH      = 16,
  parameter int BREAK_BITS = 10,
  parameter int IDLE_BITS  = 10
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     rxd_i,
  input  logic [DIV_W-1:0]         baud_div_i,
  input  logic [2:0]               char_len_i,
  input  logic                     par_en_i,
  input  logic                     par_odd_i,
  input  logic                     two_stop_i,
  input  logic [1:0]               wake_mode_i,
  input  logic                     sleep_i,
  input  logic                     rd_i,
  input  logic                     clr_err_i,
  output logic [7:0]               rd_data_o,
  output logic                     rd_addr_o,
  output logic                     rx_rdy_o,
  output logic [$clog2(DEPTH):0]   fifo_count_o,
  output logic                     err_parity_o,
  output logic                     err_overrun_o,
  output logic                     err_frame_o,
  output logic                     brk_o,
  output logic                     rx_err_o
);
  localparam int AW    = $clog2(DEPTH);
  localparam int BRK_T = BREAK_BITS * 16;
  localparam int IDL_T = IDLE_BITS * 16;
  localparam int TW    = $clog2((BRK_T > IDL_T ? BRK_T : IDL_T) + 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_ADR, S_STOP1, S_STOP2, S_BRK} st_t;

  st_t             st;
  logic [1:0]      sync;
  logic [DIV_W-1:0] div_cnt;
  logic [3:0]      ph;
  logic [1:0]      smp;
  logic [2:0]      bitn;
  logic [7:0]      shreg;
  logic            par_acc, allz, adr_bit, perr, ferr, idle_seen, frm_idle;
  logic [TW-1:0]   tcnt;
  logic [8:0]      mem [DEPTH];
  logic [AW-1:0]   wp, rp;
  logic [AW:0]     cnt;

  logic rxs, tick, vote, fin, bad_stop, is_addr, keep, full, push, pop, brk_set;
  logic [7:0] char_data;

  assign rxs       = sync[1];
  assign tick      = div_cnt == '0;
  assign vote      = (smp[1] & smp[0]) | (smp[1] & rxs) | (smp[0] & rxs);
  assign fin       = tick && ph == 4'd9 && ((st == S_STOP1 && !two_stop_i) || st == S_STOP2);
  assign bad_stop  = !vote || (st == S_STOP2 && ferr);
  assign char_data = shreg >> (3'd7 - char_len_i);
  assign is_addr   = (wake_mode_i == 2'd1) ? frm_idle : (wake_mode_i == 2'd2) ? adr_bit : 1'b0;
  assign keep      = fin && (!sleep_i || is_addr);
  assign full      = cnt == (AW+1)'(DEPTH);
  assign push      = keep && !full;
  assign pop       = rd_i && cnt != '0;
  assign brk_set   = tick && st == S_BRK && !rxs && allz && tcnt == TW'(BRK_T - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync <= 2'b11; div_cnt <= '0; st <= S_IDLE; ph <= '0; smp <= '0;
      bitn <= '0; shreg <= '0; tcnt <= '0;
      par_acc <= 1'b0; allz <= 1'b0; adr_bit <= 1'b0; perr <= 1'b0;
      ferr <= 1'b0; idle_seen <= 1'b0; frm_idle <= 1'b0;
    end else begin
      sync    <= {sync[0], rxd_i};
      div_cnt <= tick ? baud_div_i : div_cnt - 1'b1;
      if (tick) begin
        ph <= ph + 1'b1;
        if (ph == 4'd7 || ph == 4'd8) smp <= {smp[0], rxs};
        case (st)
          S_IDLE:
            if (!rxs) begin
              st <= S_START; ph <= 4'd1; tcnt <= '0;
              frm_idle <= idle_seen; idle_seen <= 1'b0;
            end else if (tcnt == TW'(IDL_T - 1)) idle_seen <= 1'b1;
            else tcnt <= tcnt + 1'b1;
          S_START:
            if (ph == 4'd9) begin
              if (vote) st <= S_IDLE;
              else begin
                st <= S_DATA; bitn <= '0; par_acc <= 1'b0; allz <= 1'b1;
                perr <= 1'b0; ferr <= 1'b0; adr_bit <= 1'b0;
              end
            end
          S_DATA:
            if (ph == 4'd9) begin
              shreg   <= {vote, shreg[7:1]};
              par_acc <= par_acc ^ vote;
              allz    <= allz & !vote;
              if (bitn == char_len_i)
                st <= par_en_i ? S_PAR : (wake_mode_i == 2'd2 ? S_ADR : S_STOP1);
              else bitn <= bitn + 1'b1;
            end
          S_PAR:
            if (ph == 4'd9) begin
              perr <= vote != (par_acc ^ par_odd_i);
              allz <= allz & !vote;
              st   <= wake_mode_i == 2'd2 ? S_ADR : S_STOP1;
            end
          S_ADR:
            if (ph == 4'd9) begin
              adr_bit <= vote; allz <= allz & !vote; st <= S_STOP1;
            end
          S_STOP1:
            if (ph == 4'd9 && two_stop_i) begin
              ferr <= !vote; st <= S_STOP2;
            end
          S_BRK:
            if (rxs) begin
              st <= S_IDLE; tcnt <= '0;
            end else if (allz && tcnt != TW'(BRK_T)) tcnt <= tcnt + 1'b1;
          default: ;
        endcase
        if (fin) begin
          st   <= bad_stop ? S_BRK : S_IDLE;
          allz <= allz && !vote && (st == S_STOP1 || ferr);
          tcnt <= '0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_parity_o <= 1'b0; err_frame_o <= 1'b0; err_overrun_o <= 1'b0; brk_o <= 1'b0;
    end else begin
      err_parity_o  <= (err_parity_o  & !clr_err_i) | (keep & perr & par_en_i);
      err_frame_o   <= (err_frame_o   & !clr_err_i) | (keep & bad_stop);
      err_overrun_o <= (err_overrun_o & !clr_err_i) | (keep & full);
      brk_o         <= (brk_o         & !clr_err_i) | brk_set;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= {is_addr, char_data};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; cnt <= '0;
    end else begin
      if (push) wp <= wp + 1'b1;
      if (pop)  rp <= rp + 1'b1;
      cnt <= cnt + (AW+1)'(push) - (AW+1)'(pop);
    end
  end

  assign rd_data_o    = mem[rp][7:0];
  assign rd_addr_o    = mem[rp][8];
  assign rx_rdy_o     = cnt != '0;
  assign fifo_count_o = cnt;
  assign rx_err_o     = err_parity_o | err_frame_o | err_overrun_o | brk_o;
endmodule

// File: rtl/nrz_rx_wake_chk.sv
module nrz_rx_wake_chk #(
  parameter int DEPTH = 16
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   rxd_i,
  input logic                   rd_i,
  input logic                   clr_err_i,
  input logic [$clog2(DEPTH):0] fifo_count_o,
  input logic                   err_parity_o,
  input logic                   err_frame_o,
  input logic                   err_overrun_o,
  input logic                   brk_o
);
  p_count_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_count_o <= ($clog2(DEPTH)+1)'(DEPTH));

  p_pop_no_grow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_i && fifo_count_o != '0 |=> fifo_count_o <= $past(fifo_count_o));

  p_overrun_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_overrun_o) |-> $past(fifo_count_o) == ($clog2(DEPTH)+1)'(DEPTH));

  p_par_sticky_r13: assert property (@(posedge clk) disable iff (!rst_n)
    err_parity_o && !clr_err_i |=> err_parity_o);

  p_frame_sticky_r13: assert property (@(posedge clk) disable iff (!rst_n)
    err_frame_o && !clr_err_i |=> err_frame_o);

  p_brk_line_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(brk_o) |-> $past(rxd_i, 3) == 1'b0);
endmodule

bind nrz_rx_wake nrz_rx_wake_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .rxd_i(rxd_i), .rd_i(rd_i), .clr_err_i(clr_err_i),
  .fifo_count_o(fifo_count_o), .err_parity_o(err_parity_o), .err_frame_o(err_frame_o),
  .err_overrun_o(err_overrun_o), .brk_o(brk_o)
);

// File: tb/nrz_rx_wake_bench.sv
`timescale 1ns/1ps
module nrz_rx_wake_bench;
  localparam int DEPTH = 16;

  logic clk = 1'b0, rst_n = 1'b0, rxd = 1'b1;
  logic [15:0] div = 16'd2;
  logic [2:0] lenc = 3'd7;
  logic pe = 1'b0, po = 1'b0, ts = 1'b0, slp = 1'b0, rd = 1'b0, clr = 1'b0;
  logic [1:0] wm = 2'd0;
  logic [7:0] rd_data;
  logic rd_addr, rx_rdy, e_par, e_ovr, e_frm, brk, rx_err;
  logic [4:0] cnt;

  always #2 clk = ~clk;

  nrz_rx_wake u_nrz_rx_wake (
    .clk(clk), .rst_n(rst_n), .rxd_i(rxd), .baud_div_i(div), .char_len_i(lenc),
    .par_en_i(pe), .par_odd_i(po), .two_stop_i(ts), .wake_mode_i(wm), .sleep_i(slp),
    .rd_i(rd), .clr_err_i(clr), .rd_data_o(rd_data), .rd_addr_o(rd_addr),
    .rx_rdy_o(rx_rdy), .fifo_count_o(cnt), .err_parity_o(e_par), .err_overrun_o(e_ovr),
    .err_frame_o(e_frm), .brk_o(brk), .rx_err_o(rx_err)
  );

  int total = 0, bad = 0, gap = 1000;
  bit busy = 1'b1, chk_on = 1'b0;
  bit m_par = 0, m_frm = 0, m_ovr = 0, m_brk = 0;
  logic [8:0] q[$];
  string req = "R12";

  always @(negedge clk) begin
    if (chk_on && !busy) begin
      int n;
      logic [8:0] head;
      n = q.size();
      head = (n != 0) ? q[0] : 9'd0;
      total++;
      if (cnt != 5'(n) || rx_rdy != (n != 0) || (n != 0 && {rd_addr, rd_data} != head)) begin
        bad++;
        $display("FAIL %s/R5 fifo: act cnt=%0d rdy=%0b head=%h exp cnt=%0d rdy=%0b head=%h",
                 req, cnt, rx_rdy, {rd_addr, rd_data}, n, n != 0, head);
      end
      total++;
      if ({e_par, e_frm, e_ovr, brk} != {m_par, m_frm, m_ovr, m_brk}) begin
        bad++;
        $display("FAIL %s flags par/frm/ovr/brk: act=%b exp=%b", req,
                 {e_par, e_frm, e_ovr, brk}, {m_par, m_frm, m_ovr, m_brk});
      end
      total++;
      if (rx_err != (m_par | m_frm | m_ovr | m_brk)) begin
        bad++;
        $display("FAIL R8 rx_err: act=%0b exp=%0b", rx_err, m_par | m_frm | m_ovr | m_brk);
      end
    end
  end

  function automatic logic [7:0] mask_of();
    return 8'((1 << (int'(lenc) + 1)) - 1);
  endfunction

  task automatic drive_bit(input logic b);
    rxd = b;
    repeat (16 * (int'(div) + 1)) @(posedge clk);
    #1;
  endtask

  task automatic idle_bits(input int n);
    for (int i = 0; i < n; i++) drive_bit(1'b1);
    gap += n;
  endtask

  task automatic send(input logic [7:0] d, input bit adr, input bit bpar, input bit bs1, input bit bs2);
    logic a;
    busy = 1'b1;
    drive_bit(1'b0);
    for (int i = 0; i <= int'(lenc); i++) drive_bit(d[i]);
    if (pe) drive_bit((^(d & mask_of())) ^ po ^ bpar);
    if (wm == 2'd2) drive_bit(adr);
    drive_bit(!bs1);
    if (ts) drive_bit(!bs2);
    drive_bit(1'b1);
    a = (wm == 2'd1) ? (gap >= 10) : (wm == 2'd2) ? adr : 1'b0;
    if (!slp || a) begin
      if (q.size() == DEPTH) m_ovr = 1;
      else q.push_back({a, d & mask_of()});
      if (pe && bpar) m_par = 1;
      if (bs1 || (ts && bs2)) m_frm = 1;
    end
    gap = 1;
    busy = 1'b0;
  endtask

  task automatic send_break(input int extra);
    int n;
    busy = 1'b1;
    n = 2 + int'(lenc) + int'(pe) + int'(ts) + 1;
    for (int i = 0; i < n + extra; i++) drive_bit(1'b0);
    drive_bit(1'b1);
    drive_bit(1'b1);
    q.push_back(9'd0);
    m_frm = 1;
    if (pe && po) m_par = 1;
    if (extra >= 10) m_brk = 1;
    gap = 2;
    busy = 1'b0;
  endtask

  task automatic glitch();
    busy = 1'b1;
    rxd = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    drive_bit(1'b1);
    drive_bit(1'b1);
    gap = 2;
    busy = 1'b0;
  endtask

  task automatic pop_all();
    while (q.size() != 0) begin
      rd = 1'b1;
      @(posedge clk); #1;
      rd = 1'b0;
      void'(q.pop_front());
    end
  endtask

  task automatic clear_flags();
    clr = 1'b1;
    @(posedge clk); #1;
    clr = 1'b0;
    m_par = 0; m_frm = 0; m_ovr = 0; m_brk = 0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    bad++;
    $display("FAIL watchdog %s: act=running exp=finished", req);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    total++;
    if (cnt != 0 || rx_rdy || {e_par, e_frm, e_ovr, brk, rx_err} != 5'b0) begin
      bad++;
      $display("FAIL R12 reset: act cnt=%0d rdy=%0b flags=%b exp cnt=0 rdy=0 flags=00000",
               cnt, rx_rdy, {e_par, e_frm, e_ovr, brk, rx_err});
    end
    @(posedge clk); #1;
    busy = 1'b0;
    chk_on = 1'b1;
    idle_bits(12);

    req = "R1";
    send(8'hA5, 0, 0, 0, 0);
    send(8'h3C, 0, 0, 0, 0);
    lenc = 3'd4; send(8'hFF, 0, 0, 0, 0);
    lenc = 3'd0; send(8'h01, 0, 0, 0, 0);
    lenc = 3'd7;
    pop_all();

    req = "R2";
    div = 16'd5; send(8'h96, 0, 0, 0, 0);
    div = 16'd0; send(8'h5A, 0, 0, 0, 0);
    div = 16'd2; glitch();
    send(8'hC3, 0, 0, 0, 0);
    pop_all();

    req = "R3";
    pe = 1'b1; po = 1'b0;
    send(8'h81, 0, 0, 0, 0);
    send(8'h81, 0, 1, 0, 0);
    clear_flags();
    po = 1'b1;
    send(8'h7E, 0, 0, 0, 0);
    send(8'h6B, 0, 1, 0, 0);
    req = "R13";
    clear_flags();
    pe = 1'b0; po = 1'b0;
    pop_all();

    req = "R4";
    ts = 1'b1;
    send(8'h11, 0, 0, 0, 0);
    send(8'h12, 0, 0, 0, 1);
    clear_flags();
    send(8'h13, 0, 0, 1, 0);
    clear_flags();
    ts = 1'b0;
    send(8'h14, 0, 0, 1, 0);
    clear_flags();
    pop_all();

    req = "R6";
    for (int i = 0; i < DEPTH + 1; i++) send(8'(i * 7 + 3), 0, 0, 0, 0);
    clear_flags();
    pop_all();

    req = "R7";
    send_break(12);
    clear_flags();
    send_break(5);
    clear_flags();
    pop_all();

    req = "R9";
    wm = 2'd1;
    idle_bits(12);
    send(8'h41, 0, 0, 0, 0);
    send(8'h42, 0, 0, 0, 0);
    idle_bits(13);
    send(8'h43, 0, 0, 0, 0);
    pop_all();

    req = "R10";
    wm = 2'd2; pe = 1'b1;
    send(8'h10, 1, 0, 0, 0);
    send(8'h20, 0, 0, 0, 0);
    pe = 1'b0;
    wm = 2'd0;
    send(8'h21, 0, 0, 0, 0);
    pop_all();

    req = "R11";
    slp = 1'b1; wm = 2'd2; pe = 1'b1;
    send(8'h30, 0, 1, 0, 0);
    send(8'h31, 1, 0, 0, 0);
    pe = 1'b0; wm = 2'd1;
    send(8'h32, 0, 0, 1, 0);
    idle_bits(13);
    send(8'h33, 0, 0, 0, 0);
    slp = 1'b0; wm = 2'd0;
    pop_all();

    repeat (4) @(posedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule